// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives one pulse-width-modulated output. An 8-bit period timer counts from zero up to a programmed limit. Two low-order sub-count bits extend it into a 10-bit compare base. A prescaler sets how many input clocks each step of that base lasts: 1, 4 or 16.

The requested duty is a 10-bit value built from two fields: an 8-bit upper part and a 2-bit lower part. Both fields may change at any time. The comparator never reads them directly. It works from a shadow copy, and that copy is refreshed only at the period boundary, so a duty change mid-period cannot cut a pulse short or stretch it.

At each boundary the output goes high, unless the new duty is zero. It falls when the compare base reaches the shadow duty. A duty the base can never reach keeps the output high for the whole period.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: One period lasts (period_i + 1) × 4 × N input clocks, where N is the prescale ratio. The output rises on the first cycle of each period when the shadow duty is nonzero. With 1 ≤ duty ≤ 4·period_i + 3, the output is low on the last cycle of the period.
- R2: The duty D is {duty_hi_i, duty_lo_i}: duty_hi_i holds bits 9..2 and duty_lo_i holds bits 1..0. With D nonzero and at most 4·period_i + 3, the output is high for exactly D × N clocks per period.
- R3: A shadow duty of zero keeps the output low for the whole period.
- R4: A duty of 4·period_i + 4 or more keeps the output high for the whole period.
- R5: A duty change made inside a period has no effect on that period's pulse. It first takes effect in the period that follows.
- R6: ps_sel_i selects the prescale ratio N: code 0 gives 1, code 1 gives 4, and codes 2 and 3 give 16.
- R7: While en_i is low, the counters are held at zero and the output is low. The first period starts in the cycle in which en_i is first seen high. That first period has no boundary set, so the output stays low throughout it.
- R8: While rst_ni is low, the output is low and the shadow duty is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| period_i | input | 8 | Period limit for the timer |
| duty_hi_i | input | 8 | Duty bits 9..2 |
| duty_lo_i | input | 2 | Duty bits 1..0 |
| ps_sel_i | input | 2 | Prescale code |
| pwm_o | output | 1 | PWM output |

## Verification
The output register is loaded from the next-cycle state of the timer and sub-counter. It therefore shows the level that belongs to the same cycle as the compare base, with no extra lag.

With en_i first seen high in cycle 0, period k spans cycles k·P to (k+1)·P − 1, where P = (period_i + 1)·4·N. The rising edge lands in cycle P, and a pulse of D·N clocks ends at cycle P + D·N − 1.

The bench drives its inputs on the falling clock edge and samples pwm_o one falling edge per cycle. It indexes each sample by cycle number, counts the high cycles in each period, and compares that count with the value computed from these formulas. A duty change is applied a few cycles into a period, and the bench expects the old pulse width in that period and the new one in the next.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int unsigned TMR_W    = 8;
  localparam int unsigned SUB_W    = 2;
  localparam int unsigned PS_SEL_W = 2;
  localparam int unsigned PS_SHIFT_MAX = 4;  // log2 of the largest ratio
  localparam int unsigned DUTY_W   = TMR_W + SUB_W;

  typedef enum logic [PS_SEL_W-1:0] {
    PS_DIV1  = 2'd0,
    PS_DIV4  = 2'd1,
    PS_DIV16 = 2'd2,
    PS_DIV16_ALT = 2'd3
  } ps_sel_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned SUB_W = pwm_dbuf_pkg::SUB_W,
  parameter int unsigned PS_SEL_W = pwm_dbuf_pkg::PS_SEL_W,
  parameter int unsigned SHIFT_MAX = pwm_dbuf_pkg::PS_SHIFT_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  output logic                tick_o,
  output logic [SUB_W-1:0]    sub_d_o
);
  localparam int unsigned FINE_W = SUB_W + SHIFT_MAX;

  logic [FINE_W-1:0] fine_q, fine_d, term;
  int unsigned shift;

  always_comb begin
    unique case (pwm_dbuf_pkg::ps_sel_e'(ps_sel_i))
      pwm_dbuf_pkg::PS_DIV1: shift = 0;
      pwm_dbuf_pkg::PS_DIV4: shift = 2;
      default:               shift = SHIFT_MAX;
    endcase
    term   = FINE_W'((32'd1 << (SUB_W + shift)) - 32'd1);
    // >= so that a ratio lowered mid-count still wraps
    tick_o = en_i && (fine_q >= term);
    if (!en_i || tick_o) fine_d = '0;
    else                 fine_d = fine_q + 1'b1;
    sub_d_o = SUB_W'(fine_d >> shift);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fine_q <= '0;
    else         fine_q <= fine_d;

  assert_idle_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fine_q == '0));
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int unsigned TMR_W = pwm_dbuf_pkg::TMR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_d_o,
  output logic             period_end_o
);
  logic [TMR_W-1:0] tmr_q;

  always_comb begin
    period_end_o = tick_i && (tmr_q >= period_i);
    if (!en_i || period_end_o) tmr_d_o = '0;
    else if (tick_i)           tmr_d_o = tmr_q + 1'b1;
    else                       tmr_d_o = tmr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= tmr_d_o;

  assert_wrap_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> (tmr_q == '0));
  assert_hold_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tmr_q == '0));
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int unsigned TMR_W = pwm_dbuf_pkg::TMR_W,
  parameter int unsigned SUB_W = pwm_dbuf_pkg::SUB_W,
  localparam int unsigned DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              period_end_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [TMR_W-1:0]  tmr_d_i,
  input  logic [SUB_W-1:0]  sub_d_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] shadow_q, base_d;
  logic pwm_q, pwm_d;

  // compare against next-cycle base so the output aligns with it
  always_comb begin
    base_d = {tmr_d_i, sub_d_i};
    if (!en_i)                   pwm_d = 1'b0;
    else if (period_end_i)       pwm_d = (duty_i != '0);
    else if (base_d == shadow_q) pwm_d = 1'b0;
    else                         pwm_d = pwm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (period_end_i) shadow_q <= duty_i;
      pwm_q <= pwm_d;
    end

  assign pwm_o = pwm_q;

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> (shadow_q == $past(duty_i)));
  assert_shadow_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_i |=> $stable(shadow_q));
  assert_zero_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_i && duty_i == '0) |=> !pwm_o);
  assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
  parameter int unsigned TMR_W = pwm_dbuf_pkg::TMR_W,
  parameter int unsigned SUB_W = pwm_dbuf_pkg::SUB_W,
  parameter int unsigned PS_SEL_W = pwm_dbuf_pkg::PS_SEL_W,
  parameter int unsigned SHIFT_MAX = pwm_dbuf_pkg::PS_SHIFT_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [TMR_W-1:0]    period_i,
  input  logic [TMR_W-1:0]    duty_hi_i,
  input  logic [SUB_W-1:0]    duty_lo_i,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  output logic                pwm_o
);
  logic             tick, period_end;
  logic [SUB_W-1:0] sub_d;
  logic [TMR_W-1:0] tmr_d;

  pwm_prescale #(.SUB_W(SUB_W), .PS_SEL_W(PS_SEL_W), .SHIFT_MAX(SHIFT_MAX)) u_pre (
    .clk_i, .rst_ni, .en_i, .ps_sel_i,
    .tick_o(tick), .sub_d_o(sub_d)
  );

  pwm_period_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .period_i,
    .tmr_d_o(tmr_d), .period_end_o(period_end)
  );

  pwm_duty_cmp #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_cmp (
    .clk_i, .rst_ni, .en_i, .period_end_i(period_end),
    .duty_i({duty_hi_i, duty_lo_i}), .tmr_d_i(tmr_d), .sub_d_i(sub_d),
    .pwm_o
  );

  assert_reset_low_R8: assert property (@(posedge clk_i)
    !rst_ni |-> !pwm_o);
endmodule

// File: tb/pwm_dbuf_gen_test.sv
`timescale 1ns/1ps
module pwm_dbuf_gen_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic [7:0] period = '0, duty_hi = '0;
  logic [1:0] duty_lo = '0, ps_sel = '0;
  logic pwm;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwm_dbuf_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .period_i(period),
    .duty_hi_i(duty_hi), .duty_lo_i(duty_lo), .ps_sel_i(ps_sel), .pwm_o(pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int ps);
    return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
  endfunction

  function automatic int hi_exp(input int p, input int d, input int ps);
    int maxb = 4 * (p + 1);
    if (d >= maxb) return maxb * ratio(ps);
    return d * ratio(ps);
  endfunction

  task automatic set_duty(input int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d);
  endtask

  // en rises at a negedge: sample k is cycle k of the run
  task automatic run(input int p, input int d, input int ps,
                     input int chg_at, input int d2, input string tag);
    int bigp = (p + 1) * 4 * ratio(ps);
    int cnt[3] = '{0, 0, 0};
    int start_s = 0, end_s = 0;
    int maxb = 4 * (p + 1);
    en = 1'b0;
    period = 8'(p);
    ps_sel = 2'(ps);
    set_duty(d);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 3 * bigp; i++) begin
      if (i == chg_at) set_duty(d2);
      if (pwm) cnt[i / bigp]++;
      if (i == bigp) start_s = int'(pwm);
      if (i == 2 * bigp - 1) end_s = int'(pwm);
      @(negedge clk);
    end
    en = 1'b0;
    chk({tag, " R7 first period low"}, cnt[0], 0);
    if (chg_at < 0) begin
      chk({tag, (d == 0) ? " R3" : (d >= maxb) ? " R4" : " R2", " high p2"},
          cnt[1], hi_exp(p, d, ps));
      chk({tag, " R6 high p3"}, cnt[2], hi_exp(p, d, ps));
      chk({tag, " R1 rise"}, start_s, int'(d != 0));
      chk({tag, " R1 last cycle"}, end_s, int'(d >= maxb));
    end else begin
      chk({tag, " R5 old duty kept"}, cnt[1], hi_exp(p, d, ps));
      chk({tag, " R5 new duty next"}, cnt[2], hi_exp(p, d2, ps));
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int plist[4] = '{0, 1, 3, 5};
    @(negedge clk);
    chk("R8 reset low", int'(pwm), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R7: idle with nonzero duty
    set_duty(9);
    period = 8'd2;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm) begin chk("R7 idle low", 1, 0); break; end
    end
    chk("R7 idle low", int'(pwm), 0);

    foreach (plist[pi]) begin
      for (int ps = 0; ps < 4; ps++) begin
        int p = plist[pi];
        int dl[5] = '{0, 1, 2 * p + 1, 4 * p + 3, 4 * p + 4};
        foreach (dl[di]) run(p, dl[di], ps, -1, 0, "sweep");
      end
    end
    run(255, 1000, 0, -1, 0, "wide");
    run(255, 1023, 0, -1, 0, "wide max");
    // R2: field split, hi=1 lo=1 -> 5
    run(3, 5, 0, -1, 0, "split");
    // R5: mid-period duty change
    run(3, 5, 0, 16 + 2, 10, "chg");
    run(3, 12, 1, 64 + 5, 3, "chg ps4");
    run(2, 0, 0, 12 + 1, 7, "chg from zero");

    // R8: reset mid-run clears output and shadow
    period = 8'd3; ps_sel = 2'd0; set_duty(6);
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 running high", int'(pwm), 1);
    rst_ni = 1'b0;
    #1;
    chk("R8 reset drops output", int'(pwm), 0);
    en = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    en = 1'b1;
    begin
      int c = 0;
      for (int i = 0; i < 16; i++) begin
        if (pwm) c++;
        @(negedge clk);
      end
      chk("R8 shadow cleared first period", c, 0);
      c = 0;
      for (int i = 0; i < 16; i++) begin
        if (pwm) c++;
        @(negedge clk);
      end
      chk("R8 duty after reset", c, 6);
    end
    en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule